// File: doc/BRIEF.md
# Oscillator-Loss Detector with Clock Failover

This block watches an external oscillator using a free-running reference clock that does not depend on that oscillator. Each rising oscillator edge flips a toggle flop. The toggle crosses into the reference domain through a synchronizer, and every change seen there restarts a quiet-cycle counter. If the counter reaches its limit, the oscillator is declared lost. The block then raises an interrupt request and moves the CPU clock output from the oscillator to the reference clock through a glitch-free handshake multiplexer.

Monitoring runs only while the reference clock is enabled (`ref_en_i`, which models whether the PLL is on). A strap pin is also captured once when reset ends: if it is low, monitoring is off until the next reset. The failure state is held until reset, so once the block has moved to the emergency clock it stays there. Software clears the interrupt flag with a one-cycle pulse.

Top module: `osc_loss_monitor`

## Requirements
- R1: While `rst_ni` is low, `fail_o`, `irq_o`, `on_ref_o` and `cpu_clk_o` are all 0.
- R2: A running oscillator does not cause a failure. This holds whenever its rising edges are at most 28 reference cycles apart and its rate is below half the reference rate.
- R3: After the last rising oscillator edge, `fail_o` rises after no fewer than 31 and no more than 37 reference rising edges. The window is TIMEOUT = 32 quiet cycles plus synchronizer latency.
- R4: `irq_o` goes high in the same cycle that `fail_o` rises. It stays high until `irq_clr_i` is sampled high on a reference edge. If a new failure and a clear fall on the same edge, the failure wins.
- R5: `fail_o` and `on_ref_o` stay high until `rst_ni` goes low, even if the oscillator starts running again.
- R6: Within 5 reference cycles of `fail_o` rising, `on_ref_o` is 1. From then on, `cpu_clk_o` follows `ref_clk_i`. `on_ref_o` is never 1 while `fail_o` is 0.
- R7: After reset, and before any failure, `cpu_clk_o` follows `osc_clk_i` once two oscillator periods have passed.
- R8: `cpu_clk_o` never shows a high or low phase shorter than the shorter half-period of the two clocks. The two source gates are never on together.
- R9: While `ref_en_i` is 0, the quiet counter is held at zero and no failure or interrupt arises. When `ref_en_i` returns to 1 with the oscillator stopped, `fail_o` rises after 31 to 34 reference edges.
- R10: `strap_i` is captured at the first reference rising edge after `rst_ni` rises. A captured 0 disables monitoring until the next reset, whatever `strap_i` does later. A captured 1 enables monitoring.
- R11: A failure is detected and the switch completes whether the oscillator stops at a high level or at a low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk_i | input | 1 | External oscillator clock being watched |
| ref_clk_i | input | 1 | Independent free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset, released in step with `ref_clk_i` |
| ref_en_i | input | 1 | 1 when the reference clock source is on; 0 suspends monitoring |
| strap_i | input | 1 | Strap pin captured at end of reset; 0 turns monitoring off |
| irq_clr_i | input | 1 | Clears the interrupt flag (reference domain) |
| cpu_clk_o | output | 1 | Gated CPU clock: oscillator, or reference after failover |
| irq_o | output | 1 | Sticky oscillator-loss interrupt request |
| fail_o | output | 1 | Oscillator declared lost; held until reset |
| on_ref_o | output | 1 | CPU clock is now taken from the reference clock |

## Verification
A quiet counter with a wrong value shows up at `fail_o`. If it is stuck, the fall-back never happens. If it is cleared badly, a false loss appears during the slow-oscillator run within one window of 32 cycles. A broken toggle or synchronizer path makes a healthy oscillator look dead within about 35 reference cycles. A lost failure latch or a failed handshake shows within a few cycles as `on_ref_o` dropping or as `cpu_clk_o` stopping tracking the reference clock. A wrongly captured strap changes whether `fail_o` rises in the stopped-oscillator tests.

// File: rtl/osc_mon_pkg.sv
`timescale 1ns/1ps
package osc_mon_pkg;
  localparam int unsigned DefTimeout    = 32;
  localparam int unsigned DefSyncStages = 2;
endpackage

// File: rtl/cdc_sync_bit.sv
`timescale 1ns/1ps
module cdc_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
module osc_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic edge_o
);
  logic tog_q, tog_s, prev_q;

  // one level change per oscillator rising edge
  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  cdc_sync_bit #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (tog_q),
    .q_o    (tog_s)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= tog_s;
  end

  assign edge_o = tog_s ^ prev_q;
endmodule

// File: rtl/osc_loss_timer.sv
`timescale 1ns/1ps
module osc_loss_timer #(
  parameter int unsigned TIMEOUT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  input  logic strap_i,
  input  logic edge_i,
  input  logic irq_clr_i,
  output logic fail_o,
  output logic irq_o
);
  localparam int unsigned CntW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CntW-1:0] CntLim = CntW'(TIMEOUT - 1);

  logic            strap_done_q, mon_allow_q;
  logic [CntW-1:0] cnt_q;
  logic            fail_q, irq_q;
  logic            active, trip;

  // strap captured once, first ref edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      mon_allow_q  <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      mon_allow_q  <= strap_i;
    end
  end

  assign active = ref_en_i & mon_allow_q & ~fail_q;
  assign trip   = active & ~edge_i & (cnt_q == CntLim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (!active || edge_i)  cnt_q <= '0;
      else if (cnt_q != CntLim) cnt_q <= cnt_q + 1'b1;
      if (trip) fail_q <= 1'b1;
      if (trip)           irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign fail_o = fail_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/glitchless_clk_mux.sv
`timescale 1ns/1ps
module glitchless_clk_mux #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic sel_ref_i,
  output logic cpu_clk_o,
  output logic osc_gate_o,
  output logic ref_gate_o
);
  logic osc_arst_n;
  logic osc_pre_q, osc_gate_q;
  logic osc_gate_s;
  logic ref_pre_q, ref_gate_q;

  // a dead oscillator cannot clock its own gate off: selecting ref clears it
  assign osc_arst_n = rst_ni & ~sel_ref_i;

  always_ff @(posedge osc_clk_i or negedge osc_arst_n) begin
    if (!osc_arst_n) osc_pre_q <= 1'b0;
    else             osc_pre_q <= 1'b1;
  end

  always_ff @(negedge osc_clk_i or negedge osc_arst_n) begin
    if (!osc_arst_n) osc_gate_q <= 1'b0;
    else             osc_gate_q <= osc_pre_q;
  end

  cdc_sync_bit #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .d_i    (osc_gate_q),
    .q_o    (osc_gate_s)
  );

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_pre_q <= 1'b0;
    else         ref_pre_q <= sel_ref_i & ~osc_gate_s;
  end

  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_gate_q <= 1'b0;
    else         ref_gate_q <= ref_pre_q;
  end

  assign cpu_clk_o  = (osc_clk_i & osc_gate_q) | (ref_clk_i & ref_gate_q);
  assign osc_gate_o = osc_gate_q;
  assign ref_gate_o = ref_gate_q;
endmodule

// File: rtl/osc_loss_monitor.sv
`timescale 1ns/1ps
module osc_loss_monitor
  import osc_mon_pkg::*;
#(
  parameter int unsigned TIMEOUT     = DefTimeout,
  parameter int unsigned SYNC_STAGES = DefSyncStages
) (
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic ref_en_i,
  input  logic strap_i,
  input  logic irq_clr_i,
  output logic cpu_clk_o,
  output logic irq_o,
  output logic fail_o,
  output logic on_ref_o
);
  logic osc_edge;
  logic fail;
  logic osc_gate, ref_gate;

  osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .osc_clk_i (osc_clk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .edge_o    (osc_edge)
  );

  osc_loss_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .ref_en_i  (ref_en_i),
    .strap_i   (strap_i),
    .edge_i    (osc_edge),
    .irq_clr_i (irq_clr_i),
    .fail_o    (fail),
    .irq_o     (irq_o)
  );

  glitchless_clk_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .osc_clk_i  (osc_clk_i),
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .sel_ref_i  (fail),
    .cpu_clk_o  (cpu_clk_o),
    .osc_gate_o (osc_gate),
    .ref_gate_o (ref_gate)
  );

  assign fail_o   = fail;
  assign on_ref_o = ref_gate;
endmodule

// File: rtl/osc_loss_monitor_chk.sv
`timescale 1ns/1ps
module osc_loss_monitor_chk (
  input logic ref_clk_i,
  input logic rst_ni,
  input logic ref_en_i,
  input logic irq_clr_i,
  input logic irq_o,
  input logic fail_o,
  input logic on_ref_o,
  input logic osc_gate_i,
  input logic ref_gate_i
);
  AST_IRQ_ON_FAIL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> irq_o); // R4

  AST_IRQ_CLEAR: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (irq_clr_i && fail_o) |=> !irq_o); // R4

  AST_FAIL_STICKY: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o); // R5

  AST_REF_NEEDS_FAIL: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    on_ref_o |-> fail_o); // R6

  AST_GATES_EXCLUSIVE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !(osc_gate_i && ref_gate_i)); // R8

  AST_NO_FAIL_WHEN_OFF: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!ref_en_i && !fail_o) |=> !fail_o); // R9
endmodule

bind osc_loss_monitor osc_loss_monitor_chk u_chk (
  .ref_clk_i  (ref_clk_i),
  .rst_ni     (rst_ni),
  .ref_en_i   (ref_en_i),
  .irq_clr_i  (irq_clr_i),
  .irq_o      (irq_o),
  .fail_o     (fail_o),
  .on_ref_o   (on_ref_o),
  .osc_gate_i (osc_gate),
  .ref_gate_i (ref_gate)
);

// File: tb/tb_osc_loss_monitor.sv
`timescale 1ns/1ps
module tb_osc_loss_monitor;
  logic osc_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic ref_en  = 1'b1;
  logic strap   = 1'b1;
  logic irq_clr = 1'b0;
  logic cpu_clk, irq, fail, on_ref;

  bit osc_run  = 1'b0;
  bit osc_lvl  = 1'b0;
  int osc_half = 23;

  int checks = 0;
  int errors = 0;

  realtime last_t = 0.0;
  bit      trk = 1'b0;
  int      glitch_cnt = 0;

  osc_loss_monitor dut (
    .osc_clk_i (osc_clk),
    .ref_clk_i (ref_clk),
    .rst_ni    (rst_n),
    .ref_en_i  (ref_en),
    .strap_i   (strap),
    .irq_clr_i (irq_clr),
    .cpu_clk_o (cpu_clk),
    .irq_o     (irq),
    .fail_o    (fail),
    .on_ref_o  (on_ref)
  );

  always #10 ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (osc_run) begin
        osc_clk = 1'b1; #(osc_half);
        osc_clk = 1'b0; #(osc_half);
      end else begin
        osc_clk = osc_lvl; #1;
      end
    end
  end

  // shortest phase on the CPU clock while out of reset
  always @(cpu_clk) begin
    if (rst_n) begin
      if (trk && (($realtime - last_t) < 9.5)) glitch_cnt++;
      trk    = 1'b1;
      last_t = $realtime;
    end else begin
      trk = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge ref_clk);
    #5;
  endtask

  task automatic do_reset(input logic s);
    rst_n    = 1'b0;
    osc_half = 23;
    osc_run  = 1'b1;
    ref_en   = 1'b1;
    irq_clr  = 1'b0;
    strap    = s;
    edges(4);
    // R1: all outputs quiet during reset
    chk(fail == 0,    "R1 fail in reset",    fail,    0);
    chk(irq == 0,     "R1 irq in reset",     irq,     0);
    chk(on_ref == 0,  "R1 on_ref in reset",  on_ref,  0);
    chk(cpu_clk == 0, "R1 cpu_clk in reset", cpu_clk, 0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    edges(3);
    strap = 1'b1;
    edges(6);
  endtask

  task automatic follow_osc(input string req);
    repeat (6) begin
      @(posedge osc_clk); #3;
      chk(cpu_clk == 1, req, cpu_clk, 1);
      @(negedge osc_clk); #3;
      chk(cpu_clk == 0, req, cpu_clk, 0);
    end
  endtask

  task automatic follow_ref(input string req);
    repeat (6) begin
      @(posedge ref_clk); #3;
      chk(cpu_clk == 1, req, cpu_clk, 1);
      @(negedge ref_clk); #3;
      chk(cpu_clk == 0, req, cpu_clk, 0);
    end
  endtask

  task automatic stop_osc(input bit lvl);
    osc_lvl = lvl;
    osc_run = 1'b0;
    #(2 * osc_half + 3);
    @(posedge ref_clk);
  endtask

  task automatic t_healthy();
    edges(300);
    chk(fail == 0, "R2 fast osc no fail", fail, 0);
    chk(irq == 0,  "R2 fast osc no irq",  irq,  0);
    follow_osc("R7 cpu follows osc");
  endtask

  task automatic t_slow_osc();
    osc_half = 280;
    edges(2000);
    chk(fail == 0, "R2 slow osc no fail", fail, 0);
    osc_half = 23;
    edges(20);
  endtask

  task automatic t_failover(input bit lvl, input string req);
    stop_osc(lvl);
    edges(29);
    chk(fail == 0, "R3 not before window", fail, 0);
    edges(8);
    chk(fail == 1, {"R3 fail after window ", req}, fail, 1);
    chk(irq == 1,  "R4 irq raised", irq, 1);
    edges(5);
    chk(on_ref == 1, {"R6 switched to ref ", req}, on_ref, 1);
    follow_ref({"R6 cpu follows ref ", req});
  endtask

  task automatic t_clear_sticky();
    @(negedge ref_clk); irq_clr = 1'b1;
    @(negedge ref_clk); irq_clr = 1'b0;
    #3;
    chk(irq == 0,    "R4 irq cleared",       irq,    0);
    chk(fail == 1,   "R5 fail kept on clr",  fail,   1);
    osc_run = 1'b1;
    edges(200);
    chk(fail == 1,   "R5 fail sticky osc back",   fail,   1);
    chk(on_ref == 1, "R5 on_ref sticky osc back", on_ref, 1);
    chk(irq == 0,    "R4 no new irq",             irq,    0);
    follow_ref("R5 stays on ref");
  endtask

  task automatic t_ref_off();
    @(negedge ref_clk); ref_en = 1'b0;
    stop_osc(1'b0);
    edges(100);
    chk(fail == 0,   "R9 no fail while off",   fail,   0);
    chk(irq == 0,    "R9 no irq while off",    irq,    0);
    chk(on_ref == 0, "R9 no switch while off", on_ref, 0);
    @(negedge ref_clk); ref_en = 1'b1;
    edges(30);
    chk(fail == 0, "R9 count restarts at zero", fail, 0);
    edges(4);
    chk(fail == 1, "R9 fail after re-enable", fail, 1);
  endtask

  task automatic t_strap_off();
    stop_osc(1'b0);
    edges(100);
    chk(fail == 0,   "R10 strap low no fail",   fail,   0);
    chk(irq == 0,    "R10 strap low no irq",    irq,    0);
    chk(on_ref == 0, "R10 strap low no switch", on_ref, 0);
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_healthy();
    t_slow_osc();
    t_failover(1'b0, "R11 stop low");
    t_clear_sticky();

    do_reset(1'b1);
    chk(fail == 0,   "R5 reset clears fail", fail,   0);
    chk(on_ref == 0, "R5 reset clears ref",  on_ref, 0);
    follow_osc("R7 osc again after reset");
    t_failover(1'b1, "R11 stop high");

    do_reset(1'b1);
    t_ref_off();

    do_reset(1'b0);
    t_strap_off();

    do_reset(1'b1);
    follow_osc("R10 strap high monitor on");
    stop_osc(1'b0);
    edges(40);
    chk(fail == 1, "R10 strap high detects", fail, 1);

    chk(glitch_cnt == 0, "R8 no short cpu_clk phase", glitch_cnt, 0);
    summary();
    $finish;
  end
endmodule